// File: doc/BRIEF.md
# Power Rail Sequencer Controller

This controller decides when each of six supply rails (one switching converter and five linear regulators) is switched on, switched off or actively discharged. A hardware enable pin starts an ordered power-up. Each rail owns a 3-bit slot field, and every rail turns on when the tick count of the power-up phase passes its slot. An optional pre-wait of several ticks comes before the first slot, and all outputs are discharged during that wait. Removing the enable plays the same slots back in mirrored order, so the rail that came up last goes down first.

All delays are counted on a timebase tick input, nominally 128 us. Sixteen ticks after the last rail is up, the controller raises a power-good level and a one-cycle event. It then hands per-rail on/off and discharge control to register bits. An undervoltage flag drops everything at once and holds the logic in reset. A thermal-shutdown flag forces every rail off. On recovery, a 2-bit rearm field selects whether a restore-defaults pulse is issued. After every wake-up, a blanking flag tells the serial interface to refuse accesses for a fixed number of clock cycles.

Top module: `rail_sequencer`

## Requirements
- R1: A rising edge on `hw_en` in the off state starts power-up. When `pre_wait` is nonzero, the controller first waits that many ticks with every rail off and every `rail_dis` bit at 1. When `pre_wait` is zero, it goes straight to the rail phase.
- R2: During the rail phase, rail i (bit i of `rail_en`, slot field `slot_cfg[3i+2:3i]`) turns on at the tick whose count from the start of the phase is greater than its slot value, and only if `en_reg[i]` is 1. Rails with equal slots turn on at the same tick.
- R3: A falling edge on `hw_en` starts power-down. Let M be the largest slot among the rails on at that edge. Rail i turns off at the tick whose count is greater than M minus its slot. The controller returns to the off state when no rail is left on.
- R4: `pwr_good` is 0 until 16 ticks after the last sequenced rail turns on. It then goes to 1, and `pg_event` pulses high for one cycle at the same time.
- R5: `rail_dis` is all ones in the off state and during the pre-wait, and equals the inverse of `rail_en` during power-up, settling and power-down. Once power-good is reached, `rail_dis` equals `dis_reg` AND NOT `en_reg`.
- R6: Once power-good is reached and `hw_en` stays high, `rail_en` follows `en_reg` one cycle after it changes.
- R7: While `uvlo` is 1, `rail_en`, `rail_dis` and `pwr_good` are 0 from the next cycle on, and `blank` is 1.
- R8: While `tsd` is 1, `rail_en` is 0, `rail_dis` is all ones and `pwr_good` is 0 from the next cycle on. When `tsd` falls, `cfg_restore` pulses for one cycle only if `rearm` is 2'b00. If `hw_en` is still high, a new power-up then begins.
- R9: `blank` is 1 during reset and stays 1 for `BLANK_CYC` cycles after reset or `uvlo` is released. It is 0 after that.
- R10: An opposite edge on `hw_en` in the middle of a sequence aborts it and starts the other sequence from the rails that are on at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo | input | 1 | Input supply below lockout threshold |
| tsd | input | 1 | Thermal shutdown flag |
| hw_en | input | 1 | Hardware enable pin |
| tick | input | 1 | One-cycle timebase pulse (128 us) |
| slot_cfg | input | NR*SW | Per-rail slot fields, rail i at bits [SW*i +: SW] |
| pre_wait | input | SW | Ticks to wait before the first slot |
| en_reg | input | NR | Per-rail enable register bits |
| dis_reg | input | NR | Per-rail discharge register bits |
| rearm | input | 2 | Thermal recovery mode, 00 restores defaults |
| rail_en | output | NR | Per-rail enable controls |
| rail_dis | output | NR | Per-rail output discharge controls |
| pwr_good | output | 1 | Power-good status |
| pg_event | output | 1 | One-cycle pulse when power-good rises |
| blank | output | 1 | Serial access must be refused |
| cfg_restore | output | 1 | One-cycle pulse requesting default registers |

## Verification
The hardest case to reach is an abort. An opposite enable edge has to land after some rails have changed but before the sequence ends, and the mirrored power-down then works from a partial set of rails with a smaller maximum slot. The stimulus reaches this by driving the tick input from the bench. That lets the enable edge be placed between two exact ticks: after the second power-up tick, and after the first power-down tick of the shortened sequence. Each resulting rail vector is compared against the slot arithmetic of R3 and R10.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT, ST_UP, ST_SETTLE, ST_ON, ST_DOWN, ST_HOT
  } psq_state_e;
endpackage

// File: rtl/psq_wake_blank.sv
module psq_wake_blank #(
  parameter int CYC = 12500
) (
  input  logic clk,
  input  logic clr,
  output logic blank
);
  localparam int CNT_W = (CYC < 2) ? 1 : $clog2(CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)            cnt <= CNT_W'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign blank = clr | (cnt != '0);
endmodule

// File: rtl/psq_slot_match.sv
module psq_slot_match #(
  parameter int NR = 6,
  parameter int SW = 3,
  parameter int CW = 5
) (
  input  logic [NR*SW-1:0] slots,
  input  logic [NR-1:0]    mask,
  input  logic [CW-1:0]    cnt,
  input  logic [SW-1:0]    base,
  output logic [NR-1:0]    hit_up,
  output logic [NR-1:0]    hit_dn,
  output logic [SW-1:0]    max_slot
);
  for (genvar i = 0; i < NR; i++) begin : g_rail
    logic [SW-1:0] s;
    logic [SW-1:0] mirror;
    assign s         = slots[i*SW +: SW];
    assign mirror    = base - s;
    assign hit_up[i] = cnt > {{(CW-SW){1'b0}}, s};
    assign hit_dn[i] = cnt > {{(CW-SW){1'b0}}, mirror};
  end

  always_comb begin
    max_slot = '0;
    for (int i = 0; i < NR; i++)
      if (mask[i] && slots[i*SW +: SW] > max_slot) max_slot = slots[i*SW +: SW];
  end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import psq_pkg::*;
#(
  parameter int NR        = 6,
  parameter int SW        = 3,
  parameter int PG_TICKS  = 16,
  parameter int BLANK_CYC = 12500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             uvlo,
  input  logic             tsd,
  input  logic             hw_en,
  input  logic             tick,
  input  logic [NR*SW-1:0] slot_cfg,
  input  logic [SW-1:0]    pre_wait,
  input  logic [NR-1:0]    en_reg,
  input  logic [NR-1:0]    dis_reg,
  input  logic [1:0]       rearm,
  output logic [NR-1:0]    rail_en,
  output logic [NR-1:0]    rail_dis,
  output logic             pwr_good,
  output logic             pg_event,
  output logic             blank,
  output logic             cfg_restore
);
  localparam int PGW = $clog2(PG_TICKS + 1);
  localparam int CW  = (PGW > SW + 1) ? PGW : SW + 1;

  psq_state_e    state;
  logic [CW-1:0] cnt, cnt_inc;
  logic [SW-1:0] dn_base, max_on;
  logic [NR-1:0] rail_q, dis_q, hit_up, hit_dn, up_next, dn_next;
  logic          pg_q, pgev_q, restore_q, en_prev, rise, fall, hold;

  assign hold    = rst | uvlo;
  assign rise    = hw_en & ~en_prev;
  assign fall    = ~hw_en & en_prev;
  assign cnt_inc = cnt + 1'b1;
  assign up_next = tick ? (rail_q | (hit_up & en_reg)) : rail_q;
  assign dn_next = tick ? (rail_q & ~hit_dn) : rail_q;

  psq_slot_match #(.NR(NR), .SW(SW), .CW(CW)) i_match (
    .slots(slot_cfg), .mask(rail_q), .cnt(cnt_inc), .base(dn_base),
    .hit_up(hit_up), .hit_dn(hit_dn), .max_slot(max_on)
  );

  psq_wake_blank #(.CYC(BLANK_CYC)) i_blank (.clk(clk), .clr(hold), .blank(blank));

  always_ff @(posedge clk) begin
    if (hold) begin
      state <= ST_OFF; cnt <= '0; dn_base <= '0; rail_q <= '0; dis_q <= '0;
      pg_q <= 1'b0; pgev_q <= 1'b0; restore_q <= 1'b0; en_prev <= 1'b0;
    end else begin
      en_prev   <= hw_en;
      pgev_q    <= 1'b0;
      restore_q <= 1'b0;
      if (tsd && state != ST_HOT) begin
        state <= ST_HOT; rail_q <= '0; dis_q <= '1; pg_q <= 1'b0;
      end else begin
        unique case (state)
          ST_HOT: if (!tsd) begin
            restore_q <= (rearm == 2'b00);
            state     <= ST_OFF;
            en_prev   <= 1'b0;
          end
          ST_OFF: begin
            dis_q <= '1;
            if (rise) begin
              cnt   <= '0;
              state <= (pre_wait == '0) ? ST_UP : ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (fall) begin
              state <= ST_DOWN; cnt <= '0; dn_base <= max_on;
            end else if (tick) begin
              if (cnt_inc >= CW'(pre_wait)) begin state <= ST_UP; cnt <= '0; end
              else cnt <= cnt_inc;
            end
          end
          ST_UP: begin
            if (fall) begin
              state <= ST_DOWN; cnt <= '0; dn_base <= max_on;
            end else begin
              rail_q <= up_next;
              dis_q  <= ~up_next;
              if ((up_next & en_reg) == en_reg) begin state <= ST_SETTLE; cnt <= '0; end
              else if (tick) cnt <= cnt_inc;
            end
          end
          ST_SETTLE: begin
            if (fall) begin
              state <= ST_DOWN; cnt <= '0; dn_base <= max_on;
            end else if (tick) begin
              if (cnt_inc == CW'(PG_TICKS)) begin
                state <= ST_ON; pg_q <= 1'b1; pgev_q <= 1'b1; cnt <= '0;
              end else cnt <= cnt_inc;
            end
          end
          ST_ON: begin
            if (fall) begin
              state <= ST_DOWN; cnt <= '0; dn_base <= max_on; pg_q <= 1'b0;
            end else begin
              rail_q <= en_reg;
              dis_q  <= dis_reg & ~en_reg;
            end
          end
          ST_DOWN: begin
            if (rise) begin
              state <= ST_UP; cnt <= '0;
            end else if (rail_q == '0) begin
              state <= ST_OFF; dis_q <= '1;
            end else begin
              rail_q <= dn_next;
              dis_q  <= ~dn_next;
              if (dn_next == '0) state <= ST_OFF;
              else if (tick) cnt <= cnt_inc;
            end
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  assign rail_en     = rail_q;
  assign rail_dis    = dis_q;
  assign pwr_good    = pg_q;
  assign pg_event    = pgev_q;
  assign cfg_restore = restore_q;

  assert_uvlo_drop_R7: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> (rail_en == '0 && rail_dis == '0 && !pwr_good));

  assert_hot_off_R8: assert property (@(posedge clk) disable iff (hold)
    tsd |=> (rail_en == '0 && rail_dis == '1));

  assert_pg_event_R4: assert property (@(posedge clk) disable iff (hold)
    $rose(pwr_good) |-> pg_event);

  assert_up_monotonic_R2: assert property (@(posedge clk) disable iff (hold)
    (state == ST_UP && $past(state) == ST_UP) |-> ((rail_en & $past(rail_en)) == $past(rail_en)));

  assert_down_monotonic_R3: assert property (@(posedge clk) disable iff (hold)
    (state == ST_DOWN && $past(state) == ST_DOWN) |-> ((rail_en & ~$past(rail_en)) == '0));

  assert_blank_wake_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(uvlo) |-> blank);
endmodule

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1, uvlo = 1'b0, tsd = 1'b0, hw_en = 1'b0, tick = 1'b0;
  logic [17:0] slot_cfg = {3'd2, 3'd5, 3'd3, 3'd3, 3'd1, 3'd0};
  logic [2:0]  pre_wait = 3'd2;
  logic [5:0]  en_reg = 6'b111111, dis_reg = 6'b000100;
  logic [1:0]  rearm = 2'b01;
  logic [5:0]  rail_en, rail_dis;
  logic        pwr_good, pg_event, blank, cfg_restore;
  int n_vec = 0, n_bad = 0, n_pgev = 0, n_rest = 0;

  typedef struct { logic [5:0] r; logic [5:0] d; logic p; string tag; } exp_t;
  exp_t q[$];
  event ev;

  always #2 clk = ~clk;

  rail_sequencer #(.BLANK_CYC(20)) i_rail_sequencer (
    .clk(clk), .rst(rst), .uvlo(uvlo), .tsd(tsd), .hw_en(hw_en), .tick(tick),
    .slot_cfg(slot_cfg), .pre_wait(pre_wait), .en_reg(en_reg), .dis_reg(dis_reg),
    .rearm(rearm), .rail_en(rail_en), .rail_dis(rail_dis), .pwr_good(pwr_good),
    .pg_event(pg_event), .blank(blank), .cfg_restore(cfg_restore)
  );

  always @(posedge clk) begin
    if (pg_event) n_pgev++;
    if (cfg_restore) n_rest++;
  end

  task automatic drain();
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      n_vec++;
      if (rail_en !== e.r || rail_dis !== e.d || pwr_good !== e.p) begin
        n_bad++;
        $display("FAIL %s: en=%b dis=%b pg=%b expected en=%b dis=%b pg=%b",
                 e.tag, rail_en, rail_dis, pwr_good, e.r, e.d, e.p);
      end
    end
  endtask

  initial forever begin @(ev); drain(); end

  task automatic expect_o(input logic [5:0] r, input logic [5:0] d, input logic p, input string tag);
    exp_t e;
    e.r = r; e.d = d; e.p = p; e.tag = tag;
    q.push_back(e);
    -> ev;
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    cyc(2);
  endtask

  task automatic finish_run();
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(4);
    chk_int("R9 blank in reset", blank, 1);
    rst = 1'b0;
    cyc(3);
    expect_o(6'b0, 6'b111111, 1'b0, "R5 reset state off");
    chk_int("R9 blank after wake", blank, 1);
    cyc(20);
    chk_int("R9 blank released", blank, 0);

    // R1: pre-wait of 2 ticks
    hw_en = 1'b1; cyc(2);
    pulse_tick(); expect_o(6'b0, 6'b111111, 1'b0, "R1 pre-wait tick1");
    pulse_tick(); expect_o(6'b0, 6'b111111, 1'b0, "R1 pre-wait tick2");
    // R2: slots 0,1,3,3,5,2
    pulse_tick(); expect_o(6'b000001, 6'b111110, 1'b0, "R2 up t1");
    pulse_tick(); expect_o(6'b000011, 6'b111100, 1'b0, "R2 up t2");
    pulse_tick(); expect_o(6'b100011, 6'b011100, 1'b0, "R2 up t3");
    pulse_tick(); expect_o(6'b101111, 6'b010000, 1'b0, "R2 up t4 shared slot");
    pulse_tick(); expect_o(6'b101111, 6'b010000, 1'b0, "R2 up t5");
    pulse_tick(); expect_o(6'b111111, 6'b000000, 1'b0, "R2 up t6");
    for (int k = 0; k < 15; k++) pulse_tick();
    expect_o(6'b111111, 6'b000000, 1'b0, "R4 pg low at 15 ticks");
    pulse_tick();
    expect_o(6'b111111, 6'b000000, 1'b1, "R4 pg high at 16 ticks");
    chk_int("R4 pg_event count", n_pgev, 1);

    // R6 and R5 in the on state
    en_reg = 6'b111011; cyc(2);
    expect_o(6'b111011, 6'b000100, 1'b1, "R6 R5 register control");
    en_reg = 6'b111111; cyc(2);
    expect_o(6'b111111, 6'b000000, 1'b1, "R6 register restore");

    // R3: mirrored power-down with M=5
    hw_en = 1'b0; cyc(2);
    expect_o(6'b111111, 6'b000000, 1'b0, "R3 down start");
    pulse_tick(); expect_o(6'b101111, 6'b010000, 1'b0, "R3 down t1");
    pulse_tick(); expect_o(6'b101111, 6'b010000, 1'b0, "R3 down t2");
    pulse_tick(); expect_o(6'b100011, 6'b011100, 1'b0, "R3 down t3");
    pulse_tick(); expect_o(6'b000011, 6'b111100, 1'b0, "R3 down t4");
    pulse_tick(); expect_o(6'b000001, 6'b111110, 1'b0, "R3 down t5");
    pulse_tick(); expect_o(6'b000000, 6'b111111, 1'b0, "R3 down t6 off");

    // R10: abort power-up, mirrored against M=1
    pre_wait = 3'd0;
    hw_en = 1'b1; cyc(2);
    pulse_tick(); pulse_tick();
    expect_o(6'b000011, 6'b111100, 1'b0, "R1 no pre-wait up t2");
    hw_en = 1'b0; cyc(2);
    pulse_tick(); expect_o(6'b000001, 6'b111110, 1'b0, "R10 abort down t1");
    pulse_tick(); expect_o(6'b000000, 6'b111111, 1'b0, "R10 abort down t2");

    // R10: abort power-down back to power-up
    hw_en = 1'b1; cyc(2);
    pulse_tick(); pulse_tick();
    hw_en = 1'b0; cyc(2);
    pulse_tick(); expect_o(6'b000001, 6'b111110, 1'b0, "R10 partial down");
    hw_en = 1'b1; cyc(2);
    pulse_tick(); expect_o(6'b000001, 6'b111110, 1'b0, "R10 re-up t1");
    pulse_tick(); expect_o(6'b000011, 6'b111100, 1'b0, "R10 re-up t2");
    for (int k = 0; k < 4; k++) pulse_tick();
    expect_o(6'b111111, 6'b000000, 1'b0, "R10 re-up complete");
    for (int k = 0; k < 16; k++) pulse_tick();
    expect_o(6'b111111, 6'b000000, 1'b1, "R4 pg after re-up");
    chk_int("R4 pg_event second", n_pgev, 2);

    // R8: thermal shutdown, rearm keeps settings
    tsd = 1'b1; cyc(2);
    expect_o(6'b0, 6'b111111, 1'b0, "R8 thermal off");
    tsd = 1'b0; cyc(4);
    chk_int("R8 no restore with rearm 01", n_rest, 0);
    pulse_tick();
    expect_o(6'b000001, 6'b111110, 1'b0, "R8 restart after recovery");
    rearm = 2'b00;
    tsd = 1'b1; cyc(2);
    expect_o(6'b0, 6'b111111, 1'b0, "R8 thermal off mid-sequence");
    tsd = 1'b0; cyc(4);
    chk_int("R8 restore with rearm 00", n_rest, 1);

    // R7 and R9: undervoltage
    uvlo = 1'b1; cyc(2);
    expect_o(6'b0, 6'b0, 1'b0, "R7 undervoltage drop");
    chk_int("R7 blank during uvlo", blank, 1);
    hw_en = 1'b0;
    uvlo = 1'b0; cyc(3);
    expect_o(6'b0, 6'b111111, 1'b0, "R7 off after uvlo");
    chk_int("R9 blank after uvlo", blank, 1);
    cyc(20);
    chk_int("R9 blank clears after uvlo", blank, 0);

    cyc(2);
    finish_run();
  end
endmodule